// File: doc/BRIEF.md
# Bus Cycle Break Comparator

This block watches every cycle on a shared on-chip bus and checks it against two independent break channels, A and B. Four masters share the bus: the CPU instruction path, the CPU data path and two DMA engines. Addresses on the bus are already physical, so each channel compares against a physical address. A channel also carries an address mask, a cycle-type select and a read/write select.

A cycle from the CPU instruction path, which includes cache read-fills caused by fetches, counts as an instruction fetch. A cycle from any other master counts as a data access. When a cycle satisfies a channel, that channel's sticky match flag is set one clock later. In the same clock, a single-cycle break request goes to the CPU, unless the CPU block bit was 1 in the matching cycle. The flag is set even when the request is held back.

Software sets up the channels and clears the flags through a simple register write port.

Top module: `bus_break_cmp`

## Requirements
- R1: After reset both match flags and the break request are 0, and both channels are disabled: every configuration field reads as zero, so no bus cycle matches until the channel is programmed.
- R2: A channel matches an address when `((bus_addr ^ chan_addr) & ~chan_mask) == 0`. Mask bits set to 1 leave that address bit out of the comparison.
- R3: `bus_master` encoding: 0 is the CPU instruction path and is an instruction fetch. 1 (CPU data path), 2 (DMA engine 0) and 3 (DMA engine 1) are data accesses.
- R4: Cycle-type field (control bits [1:0]): 00 off, 01 instruction fetch only, 10 data access only, 11 either.
- R5: Read/write field (control bits [3:2]): 00 off, 01 reads only, 10 writes only, 11 either. `bus_write`=1 marks a write. A channel whose cycle-type or read/write field is 00 never matches.
- R6: A match is evaluated only in a cycle with `bus_valid`=1. Flags and the break request change on the next rising clock edge. A cycle with `bus_valid`=0 has no effect.
- R7: A match flag stays 1 until a write to select 6 puts a 0 in that channel's bit (bit 0 = A, bit 1 = B). Writing 1 leaves the flag as it is.
- R8: If a clearing write and a new match for the same channel fall in the same cycle, the flag ends up 1.
- R9: While `cpu_block` is 1 in the matching cycle, no break request is raised, but the match flag is still set.
- R10: The break request is the OR of the A and B matches of one bus cycle. It is high for exactly one clock per matching cycle.
- R11: The channels are independent. A match on one channel does not change the other channel's flag. Register selects are 0/1/2 for A address/mask/control and 3/4/5 for B address/mask/control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_addr | input | ADDR_W | Physical address of the bus cycle |
| bus_master | input | 2 | Issuing master (0 CPU fetch, 1 CPU data, 2/3 DMA) |
| bus_write | input | 1 | 1 for a write cycle, 0 for a read |
| cpu_block | input | 1 | CPU block bit; suppresses break requests |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0..5 channel setup, 6 flags) |
| reg_wdata | input | ADDR_W | Register write data |
| match_flag | output | 2 | Sticky match flags, bit 0 = A, bit 1 = B |
| brk_req | output | 1 | One-cycle break request to the CPU |

## Verification
Two functions can act in the same cycle: a software write that clears a flag, and a bus cycle that sets that flag again. The bench provokes this by issuing the clearing flag write in the same clock as a matching bus cycle, and it does so on almost every stimulus step. The expected flag value is the new hit ORed with the old flag masked by the clear, so the set must win. The block bit and a match in the same cycle are also crossed throughout the address sweep. In those cycles the flag must rise while the break request stays low.

// File: rtl/bus_break_cmp.sv
module bus_break_cmp #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_master,
  input  logic              bus_write,
  input  logic              cpu_block,
  input  logic              reg_wr,
  input  logic [2:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [1:0]        match_flag,
  output logic              brk_req
);

  localparam int         NCH        = 2;
  localparam logic [1:0] MST_IFETCH = 2'd0;
  localparam logic [2:0] SEL_FLAGS  = 3'd6;

  logic [NCH-1:0] hit;
  logic [NCH-1:0] flag_q;
  logic           brk_q;

  wire is_ifetch = (bus_master == MST_IFETCH);
  wire flag_wr   = reg_wr && (reg_sel == SEL_FLAGS);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam logic [2:0] SEL_ADDR = 3'(3 * ch);
    localparam logic [2:0] SEL_MASK = 3'(3 * ch + 1);
    localparam logic [2:0] SEL_CTRL = 3'(3 * ch + 2);

    logic [ADDR_W-1:0] cmp_addr;
    logic [ADDR_W-1:0] cmp_mask;
    logic [1:0]        cyc_sel;
    logic [1:0]        dir_sel;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmp_addr <= '0;
        cmp_mask <= '0;
        cyc_sel  <= 2'b00;
        dir_sel  <= 2'b00;
      end else if (reg_wr) begin
        if (reg_sel == SEL_ADDR) cmp_addr <= reg_wdata;
        if (reg_sel == SEL_MASK) cmp_mask <= reg_wdata;
        if (reg_sel == SEL_CTRL) begin
          cyc_sel <= reg_wdata[1:0];
          dir_sel <= reg_wdata[3:2];
        end
      end
    end

    wire type_ok = is_ifetch ? cyc_sel[0] : cyc_sel[1];
    wire dir_ok  = bus_write ? dir_sel[1] : dir_sel[0];
    wire addr_ok = ((bus_addr ^ cmp_addr) & ~cmp_mask) == '0;

    assign hit[ch] = bus_valid & type_ok & dir_ok & addr_ok;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      brk_q  <= 1'b0;
    end else begin
      flag_q <= hit | (flag_q & ~(flag_wr ? ~reg_wdata[NCH-1:0] : '0));
      brk_q  <= (|hit) & ~cpu_block;
    end
  end

  assign match_flag = flag_q;
  assign brk_req    = brk_q;

endmodule

// File: rtl/bus_break_chk.sv
module bus_break_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_valid,
  input logic       cpu_block,
  input logic       reg_wr,
  input logic [2:0] reg_sel,
  input logic [1:0] reg_wdata,
  input logic [1:0] match_flag,
  input logic       brk_req
);

  p_brk_unblocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> $past(!cpu_block));

  p_brk_sets_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> (match_flag != 2'b00));

  p_brk_after_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> $past(bus_valid));

  p_idle_no_brk_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> !brk_req);

  p_flag_rise_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(match_flag[0]) || $rose(match_flag[1])) |-> $past(bus_valid));

  p_flag_a_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag[0] && !(reg_wr && reg_sel == 3'd6 && !reg_wdata[0])) |=> match_flag[0]);

  p_flag_b_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag[1] && !(reg_wr && reg_sel == 3'd6 && !reg_wdata[1])) |=> match_flag[1]);

endmodule

bind bus_break_cmp bus_break_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .cpu_block (cpu_block),
  .reg_wr    (reg_wr),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata[1:0]),
  .match_flag(match_flag),
  .brk_req   (brk_req)
);

// File: tb/tb_bus_break_cmp.sv
`timescale 1ns/1ps
module tb_bus_break_cmp;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_valid = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [1:0]    bus_master = 2'd0;
  logic          bus_write = 1'b0;
  logic          cpu_block = 1'b0;
  logic          reg_wr = 1'b0;
  logic [2:0]    reg_sel = 3'd0;
  logic [AW-1:0] reg_wdata = '0;
  logic [1:0]    match_flag;
  logic          brk_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [AW-1:0] m_addr [2];
  logic [AW-1:0] m_mask [2];
  logic [3:0]    m_ctrl [2];
  logic [1:0]    m_flag;

  always #2 clk = ~clk;

  bus_break_cmp #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_master(bus_master), .bus_write(bus_write), .cpu_block(cpu_block),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .match_flag(match_flag), .brk_req(brk_req)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic logic exp_hit(input int ch, input logic [AW-1:0] a,
                                   input logic [1:0] m, input logic w);
    logic ty, dr;
    ty = (m == 2'd0) ? m_ctrl[ch][0] : m_ctrl[ch][1];
    dr = w ? m_ctrl[ch][3] : m_ctrl[ch][2];
    return ty && dr && (((a ^ m_addr[ch]) & ~m_mask[ch]) == '0);
  endfunction

  task automatic cfg(input int ch, input logic [AW-1:0] a, input logic [AW-1:0] mk,
                     input logic [3:0] ctl);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_sel = 3'(3 * ch);     reg_wdata = a;             @(negedge clk);
    reg_sel = 3'(3 * ch + 1); reg_wdata = mk;            @(negedge clk);
    reg_sel = 3'(3 * ch + 2); reg_wdata = AW'(ctl);      @(negedge clk);
    reg_wr = 1'b0;
    m_addr[ch] = a; m_mask[ch] = mk; m_ctrl[ch] = ctl;
  endtask

  // One clock of stimulus; clr bit = 1 issues a clearing write for that channel.
  task automatic step(input string tag, input logic v, input logic [AW-1:0] a,
                      input logic [1:0] m, input logic w, input logic blk,
                      input logic [1:0] clr, input logic do_wr);
    logic [1:0] eh, ef;
    logic eb;
    @(negedge clk);
    bus_valid = v; bus_addr = a; bus_master = m; bus_write = w; cpu_block = blk;
    reg_wr = do_wr; reg_sel = 3'd6; reg_wdata = AW'(~clr);
    eh = v ? {exp_hit(1, a, m, w), exp_hit(0, a, m, w)} : 2'b00;
    ef = eh | (m_flag & ~(do_wr ? clr : 2'b00));
    eb = (|eh) & ~blk;
    @(negedge clk);
    bus_valid = 1'b0; reg_wr = 1'b0;
    m_flag = ef;
    chk({tag, " flags"}, 8'(match_flag), 8'(ef));
    chk({tag, " brk"}, 8'(brk_req), 8'(eb));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got=timeout exp=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      m_addr[c] = '0; m_mask[c] = '0; m_ctrl[c] = 4'd0;
    end
    m_flag = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset flags", 8'(match_flag), 8'h0);
    chk("R1 reset brk", 8'(brk_req), 8'h0);
    // R1: address 0 equals reset address, yet disabled channels never match
    for (int m = 0; m < 4; m++)
      step("R1 disabled", 1'b1, '0, 2'(m), m[0], 1'b0, 2'b00, 1'b0);

    // R3 R4 R5: every cycle-type and read/write setting against every master and direction
    cfg(1, 8'h3C, 8'h00, 4'd0);
    for (int ct = 0; ct < 16; ct++) begin
      cfg(0, 8'h3C, 8'h00, 4'(ct));
      for (int m = 0; m < 4; m++)
        for (int w = 0; w < 2; w++)
          step("R3 R4 R5", 1'b1, 8'h3C, 2'(m), w[0], 1'b0, 2'b11, 1'b1);
    end

    // R2 R11 R9 R10 R8: full address sweep with masks, both channels, block bit crossed
    cfg(0, 8'hA5, 8'h0C, 4'hF);
    cfg(1, 8'h5A, 8'h81, 4'hF);
    for (int a = 0; a < 256; a++)
      step("R2 R11 R9 R8", 1'b1, 8'(a), 2'(a >> 1), a[3], a[4], 2'b11, 1'b1);

    // R7 R6 R10: sticky flags, idle cycles, pulse width
    step("R10 idle", 1'b0, 8'h00, 2'd0, 1'b0, 1'b0, 2'b11, 1'b1);
    step("R7 set A", 1'b1, 8'hA1, 2'd2, 1'b0, 1'b0, 2'b00, 1'b0);
    step("R10 pulse end", 1'b0, 8'hA1, 2'd2, 1'b0, 1'b0, 2'b00, 1'b0);
    step("R6 invalid ignored", 1'b0, 8'h5A, 2'd1, 1'b1, 1'b0, 2'b00, 1'b0);
    step("R7 write ones", 1'b0, 8'h00, 2'd0, 1'b0, 1'b0, 2'b00, 1'b1);
    step("R11 set B", 1'b1, 8'hDB, 2'd3, 1'b1, 1'b1, 2'b00, 1'b0);
    step("R7 clear B only", 1'b0, 8'h00, 2'd0, 1'b0, 1'b0, 2'b10, 1'b1);
    step("R7 clear A", 1'b0, 8'h00, 2'd0, 1'b0, 1'b0, 2'b01, 1'b1);
    // R8: set wins over clear in the same cycle
    step("R8 set A", 1'b1, 8'hAD, 2'd0, 1'b1, 1'b0, 2'b00, 1'b0);
    step("R8 clear+hit A", 1'b1, 8'hA9, 2'd1, 1'b0, 1'b0, 2'b01, 1'b1);
    step("R8 clear+hit B", 1'b1, 8'h5B, 2'd2, 1'b0, 1'b1, 2'b11, 1'b1);
    // R10: both channels in one cycle give one pulse
    cfg(1, 8'hA5, 8'h00, 4'hF);
    step("R10 both", 1'b1, 8'hA5, 2'd0, 1'b0, 1'b0, 2'b11, 1'b1);
    step("R10 both end", 1'b0, 8'hA5, 2'd0, 1'b0, 1'b0, 2'b00, 1'b0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule